// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver with LRCK Period Monitor

This block sits behind the three-wire stereo PCM input of an audio datapath. It works in the 256fs master clock domain. The bit clock, word clock and data pins are brought into that domain through synchronisers, and their edges are found there. One shift path then assembles left and right words for six framings: I2S, MSB-justified and LSB-justified, each at 16 or 18 bits. The framing is chosen by a 3-bit format code. The words leave as 18-bit values, and a one-cycle strobe marks each completed stereo frame.

Alongside the data path, a monitor measures the number of master clock cycles between rising word-clock edges. It raises a sync-fail flag when that interval leaves a window around the nominal 256 cycles, or when the word clock stops. A downstream attenuator would use this flag to silence the output.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low and in the first cycle after its release, `left_word` and `right_word` are 0 and `frame_valid` and `sync_fail` are 0.
- R2: A data bit is taken on each rising bit-clock edge, and words arrive most significant bit first.
- R3: With justification bits `fmt_code[1:0]`=00 (I2S), the bits are taken in slots 1..N after a word-clock edge, where slot 0 is the first rising bit-clock edge after that edge. The word sent while the word clock is low goes to `left_word` at the rising edge, and the word sent while it is high goes to `right_word` at the falling edge.
- R4: With `fmt_code[1:0]`=01 (MSB-justified), the word is slots 0..N-1 after the edge, and later bits are ignored. The word sent while the word clock is high goes to `left_word` at the falling edge, and the word sent while it is low goes to `right_word` at the rising edge.
- R5: With `fmt_code[1:0]`=10 (LSB-justified), the word is the last N bits before the word-clock edge, and earlier bits are ignored. The channel assignment is the same as in R4.
- R6: `fmt_code[2]`=0 selects N=16 and `fmt_code[2]`=1 selects N=18. A 16-bit word appears in bits 17:2 of the output, and bits 1:0 are zero. Code 11 in bits 1:0 behaves as I2S.
- R7: `frame_valid` is a single-cycle pulse, raised once per frame in the cycle `right_word` takes a new word. `right_word` changes only in such a cycle, and `left_word` changes only right after a word-clock edge.
- R8: `sync_fail` is set when the interval between rising word-clock edges falls outside 246..266 master clock cycles. It is cleared by the next interval inside that window.
- R9: Once a rising word-clock edge has been seen, `sync_fail` is also set after more than 266 master clock cycles pass without a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | 256fs master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_code | input | 3 | Bit 2: word length; bits 1:0: justification |
| bck | input | 1 | Serial bit clock, asynchronous to mclk sampling |
| lrck | input | 1 | Word clock, selects the channel |
| din | input | 1 | Serial data |
| left_word | output | 18 | Last left word, left-aligned |
| right_word | output | 18 | Last right word, left-aligned |
| frame_valid | output | 1 | One-cycle pulse per completed frame |
| sync_fail | output | 1 | Word-clock period out of tolerance |

## Verification
In the justified formats, the rising word-clock edge does two jobs in the same cycle: it latches the right word and raises `frame_valid`, and it ends the period measurement that updates `sync_fail`. The bench runs its tolerance sweep in MSB-justified mode. It stretches and shrinks frames across both sides of the window (−12, −10, +10, +11 cycles) while random words keep flowing. Every strobe is compared against the words that were sent, and the flag is compared against the interval the bench itself built. A corrupted interaction therefore shows as either a data miscompare or a wrong flag.

// File: rtl/sra_pkg.sv
// Shared types for the serial audio receiver.
package sra_pkg;

    // Justification field of the format code (bits 1:0).
    typedef enum logic [1:0] {
        JUST_I2S  = 2'b00,
        JUST_MSB  = 2'b01,
        JUST_LSB  = 2'b10,
        JUST_RSVD = 2'b11
    } just_e;

    // Full format code: bit 2 selects the long word length.
    typedef struct packed {
        logic  long_word;
        just_e just;
    } fmt_t;

endpackage

// File: rtl/sra_edge_sync.sv
// Brings W asynchronous lines into the clk domain through a STAGES-deep
// flop chain and flags rising and falling edges of each synchronised line.
// Assumes every line holds each level for at least two clk cycles.
module sra_edge_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    // Shift the raw lines through the synchroniser chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= async_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];

    // Per-line edge flags.
    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise_o[g] = level_o[g] & ~prev_q[g];
        assign fall_o[g] = ~level_o[g] & prev_q[g];
    end
endmodule

// File: rtl/sra_word_capture.sv
// Assembles serial bits into left and right words for the selected framing.
// A slot counter restarts at each word-clock edge; the justification decides
// which slots enter the shifter. Assumes bit strobes and word-clock edges never
// land in the same cycle (the word clock moves on falling bit-clock edges).
module sra_word_capture
    import sra_pkg::*;
#(
    parameter int WORD_W    = 18,
    parameter int SHORT_W   = 16,
    parameter int MAX_SLOTS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_t              fmt,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              lr_rise,
    input  logic              lr_fall,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(MAX_SLOTS + 1);
    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] SLOT_MAX  = CNT_W'(MAX_SLOTS);
    localparam int PAD_W = WORD_W - SHORT_W;

    logic [WORD_W-1:0] acc_q;
    logic [CNT_W-1:0]  slot_q;
    logic [CNT_W-1:0]  word_len;
    logic              take_bit;
    logic              lr_edge;
    logic              to_left, to_right;
    logic [WORD_W-1:0] aligned;

    assign word_len = fmt.long_word ? LONG_LEN : SHORT_LEN;
    assign lr_edge  = lr_rise | lr_fall;

    // Decide whether the current slot belongs to the word.
    always_comb begin
        unique case (fmt.just)
            JUST_MSB: take_bit = (slot_q < word_len);
            JUST_LSB: take_bit = 1'b1;
            default:  take_bit = (slot_q != '0) && (slot_q <= word_len);
        endcase
    end

    // Route the word-clock edge to the channel it closes.
    always_comb begin
        if (fmt.just == JUST_MSB || fmt.just == JUST_LSB) begin
            to_left  = lr_fall;
            to_right = lr_rise;
        end else begin
            to_left  = lr_rise;
            to_right = lr_fall;
        end
    end

    // Left-align the collected bits into the output width.
    assign aligned = fmt.long_word ? acc_q
                                   : {acc_q[SHORT_W-1:0], {PAD_W{1'b0}}};

    // Slot counter and shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            slot_q <= '0;
        end else if (lr_edge) begin
            slot_q <= '0;
        end else if (bit_stb) begin
            if (take_bit) acc_q <= {acc_q[WORD_W-2:0], bit_val};
            if (slot_q != SLOT_MAX) slot_q <= slot_q + 1'b1;
        end
    end

    // Output word registers and frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= to_right;
            if (to_left)  left_o  <= aligned;
            if (to_right) right_o <= aligned;
        end
    end
endmodule

// File: rtl/sra_lr_monitor.sv
// Counts master clock cycles between rising word-clock edges and flags
// intervals outside NOMINAL +/- TOL, or a word clock that has stopped.
// The first rising edge after reset only arms the measurement.
module sra_lr_monitor #(
    parameter int NOMINAL = 256,
    parameter int TOL     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lr_rise,
    output logic fail_o
);
    localparam int HI = NOMINAL + TOL;
    localparam int LO = NOMINAL - TOL;
    localparam int CW = $clog2(HI + 3);
    localparam logic [CW-1:0] HI_V  = CW'(HI);
    localparam logic [CW-1:0] LO_V  = CW'(LO);
    localparam logic [CW-1:0] SAT_V = CW'(HI + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;
    logic          armed_q;

    assign period = cnt_q + 1'b1;

    // Measure each interval and update the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            fail_o  <= 1'b0;
        end else if (lr_rise) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (armed_q) fail_o <= (period < LO_V) || (period > HI_V);
        end else begin
            if (cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
            if (armed_q && cnt_q >= HI_V) fail_o <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
// Top of the serial audio receiver: synchronises the serial pins into the
// master clock domain, assembles stereo words and monitors word-clock timing.
// Assumes fmt_code is static while data flows and the bit clock holds each
// level for at least two mclk cycles.
module serial_audio_rx
    import sra_pkg::*;
#(
    parameter int WORD_W      = 18,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_SLOTS   = 64,
    parameter int LR_NOMINAL  = 256,
    parameter int LR_TOL      = 10
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic [2:0]        fmt_code,
    input  logic              bck,
    input  logic              lrck,
    input  logic              din,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              frame_valid,
    output logic              sync_fail
);
    localparam int IDX_BCK = 0;
    localparam int IDX_LR  = 1;
    localparam int IDX_DIN = 2;
    localparam int NLINES  = 3;

    logic [NLINES-1:0] lvl, rise, fall;
    logic              bit_stb, bit_val, lr_rise, lr_fall;
    fmt_t              fmt;

    assign fmt = fmt_t'(fmt_code);

    sra_edge_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (mclk),
        .rst_n   (rst_n),
        .async_i ({din, lrck, bck}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign bit_stb = rise[IDX_BCK];
    assign bit_val = lvl[IDX_DIN];
    assign lr_rise = rise[IDX_LR];
    assign lr_fall = fall[IDX_LR];

    sra_word_capture #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .MAX_SLOTS(MAX_SLOTS)) u_cap (
        .clk     (mclk),
        .rst_n   (rst_n),
        .fmt     (fmt),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .lr_rise (lr_rise),
        .lr_fall (lr_fall),
        .left_o  (left_word),
        .right_o (right_word),
        .valid_o (frame_valid)
    );

    sra_lr_monitor #(.NOMINAL(LR_NOMINAL), .TOL(LR_TOL)) u_mon (
        .clk     (mclk),
        .rst_n   (rst_n),
        .lr_rise (lr_rise),
        .fail_o  (sync_fail)
    );
endmodule

// File: rtl/sra_rx_checker.sv
// Temporal checks for serial_audio_rx, attached through bind.
module sra_rx_checker #(
    parameter int WORD_W  = 18,
    parameter int NOMINAL = 256,
    parameter int TOL     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lr_rise,
    input logic              lr_fall,
    input logic              valid_o,
    input logic [WORD_W-1:0] left_o,
    input logic [WORD_W-1:0] right_o,
    input logic              fail_o
);
    localparam int HI = NOMINAL + TOL;
    localparam int CW = $clog2(HI + 3);
    localparam logic [CW-1:0] TRIP_V = CW'(HI + 1);

    logic [CW-1:0] gap_q;
    logic          seen_q;

    // Independent count of cycles since the last rising word-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (lr_rise) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != TRIP_V) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);                                   // R7
    AST_RIGHT_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_o) |-> valid_o);                          // R7
    AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(lr_rise || lr_fall));                  // R7
    AST_LEFT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_o) |-> $past(lr_rise || lr_fall));         // R7
    AST_CLEAR_ON_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_o) |-> $past(lr_rise));                       // R8
    AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && gap_q == TRIP_V) |-> fail_o);                 // R9
endmodule

bind serial_audio_rx sra_rx_checker #(
    .WORD_W  (WORD_W),
    .NOMINAL (LR_NOMINAL),
    .TOL     (LR_TOL)
) u_chk (
    .clk     (mclk),
    .rst_n   (rst_n),
    .lr_rise (lr_rise),
    .lr_fall (lr_fall),
    .valid_o (frame_valid),
    .left_o  (left_word),
    .right_o (right_word),
    .fail_o  (sync_fail)
);

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
    logic        mclk = 1'b0;
    logic        rst_n;
    logic [2:0]  fmt_code;
    logic        bck, lrck, din;
    logic [17:0] left_w, right_w;
    logic        valid_w, fail_w;

    always #2.5 mclk = ~mclk;

    serial_audio_rx dut (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .fmt_code    (fmt_code),
        .bck         (bck),
        .lrck        (lrck),
        .din         (din),
        .left_word   (left_w),
        .right_word  (right_w),
        .frame_valid (valid_w),
        .sync_fail   (fail_w)
    );

    int checks = 0;
    int errs   = 0;
    logic [17:0] exp_l [256];
    logic [17:0] exp_r [256];
    int wr_i = 0;
    int rd_i = 0;
    int cur_n = 16;
    logic [1:0] cur_j = 2'b00;
    string cur_tag = "R3";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] align_word(input logic [17:0] w);
        return (cur_n == 16) ? {w[15:0], 2'b00} : w;
    endfunction

    // Bit sent in slot k of a half with s slots (R3/R4/R5 slot rules).
    function automatic logic slot_bit(input int s, input int k, input logic [17:0] w, input logic f);
        int idx;
        case (cur_j)
            2'b01:   idx = (k < cur_n) ? cur_n - 1 - k : -1;
            2'b10:   idx = (k >= s - cur_n) ? s - 1 - k : -1;
            default: idx = (k >= 1 && k <= cur_n) ? cur_n - k : -1;
        endcase
        return (idx < 0) ? f : w[idx];
    endfunction

    task automatic send_half(input logic lvl, input logic [17:0] w, input int s);
        for (int k = 0; k < s; k++) begin
            @(negedge mclk);
            bck = 1'b0;
            if (k == 0) lrck = lvl;
            din = slot_bit(s, k, w, 1'($urandom()));
            @(negedge mclk);
            @(negedge mclk);
            bck = 1'b1;
            @(negedge mclk);
        end
    endtask

    task automatic send_frame(input int s, input int pad, input logic [17:0] lw,
                              input logic [17:0] rw, input bit push);
        logic first_lvl;
        first_lvl = (cur_j == 2'b01 || cur_j == 2'b10);
        send_half(first_lvl, lw, s);
        send_half(~first_lvl, rw, s);
        repeat (pad) @(negedge mclk);
        if (push) begin
            exp_l[wr_i] = align_word(lw);
            exp_r[wr_i] = align_word(rw);
            wr_i++;
        end
    endtask

    function automatic logic [17:0] pick_word(input int k, input bit left);
        case (k)
            0: return 18'h3FFFF;
            1: return 18'h00000;
            2: return left ? 18'h2AAAA : 18'h15555;
            default: return 18'($urandom());
        endcase
    endfunction

    task automatic set_fmt(input logic [2:0] code);
        fmt_code = code;
        cur_n = code[2] ? 18 : 16;
        cur_j = code[1:0];
        cur_tag = (code[1:0] == 2'b01) ? "R4 R6" : (code[1:0] == 2'b10) ? "R5 R6" : "R3 R6";
    endtask

    task automatic run_block(input logic [2:0] code, input int nfr);
        set_fmt(code);
        send_frame(32, 0, 18'($urandom()), 18'($urandom()), 0);
        for (int k = 0; k < nfr; k++)
            send_frame(32, 0, pick_word(k, 1), pick_word(k, 0), 1);
        send_frame(32, 0, 18'($urandom()), 18'($urandom()), 0);
        chk("R7 one strobe per frame", rd_i, wr_i);
    endtask

    task automatic sync_step(input int s, input int pad, input logic expect_fail, input string req);
        for (int k = 0; k < 3; k++)
            send_frame(s, pad, 18'($urandom()), 18'($urandom()), 1);
        chk(req, fail_w, expect_fail);
    endtask

    // Compare each strobed frame with the words that were sent (R2..R7).
    always @(negedge mclk) begin
        if (rst_n && valid_w && rd_i < wr_i) begin
            chk({cur_tag, " R2 left"},  left_w,  exp_l[rd_i]);
            chk({cur_tag, " R2 right"}, right_w, exp_r[rd_i]);
            rd_i++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    endtask

    initial begin
        repeat (190000) @(posedge mclk);
        errs++;
        checks++;
        $display("FAIL watchdog R1..all actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1));
        rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; din = 1'b0; fmt_code = 3'b000;
        repeat (5) @(negedge mclk);
        chk("R1 left in reset", left_w, 18'h0);
        chk("R1 strobe in reset", valid_w, 1'b0);
        @(negedge mclk);
        rst_n = 1'b1;
        @(negedge mclk);
        chk("R1 left after reset", left_w, 18'h0);
        chk("R1 right after reset", right_w, 18'h0);
        chk("R1 strobe after reset", valid_w, 1'b0);
        chk("R1 sync flag after reset", fail_w, 1'b0);

        run_block(3'b000, 6);
        run_block(3'b001, 6);
        run_block(3'b010, 6);
        run_block(3'b100, 6);
        run_block(3'b101, 6);
        run_block(3'b110, 6);
        run_block(3'b011, 4);

        // Tolerance sweep in MSB-justified mode with data flowing.
        set_fmt(3'b001);
        send_frame(32, 0, 18'($urandom()), 18'($urandom()), 0);
        sync_step(32, 0,  1'b0, "R8 nominal period");
        sync_step(30, 4,  1'b1, "R8 period 244");
        sync_step(30, 6,  1'b0, "R8 period 246 clears");
        sync_step(32, 11, 1'b1, "R8 period 267");
        sync_step(32, 10, 1'b0, "R8 period 266 clears");
        send_frame(32, 0, 18'($urandom()), 18'($urandom()), 0);
        chk("R7 one strobe per frame in sweep", rd_i, wr_i);

        // Stopped word clock.
        repeat (400) @(negedge mclk);
        chk("R9 stalled word clock", fail_w, 1'b1);
        for (int k = 0; k < 3; k++)
            send_frame(32, 0, 18'($urandom()), 18'($urandom()), 0);
        chk("R8 recovery after stall", fail_w, 1'b0);

        summary();
        $finish;
    end
endmodule